// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Low-Power Wake

This block sits beside a small CPU core and turns seventeen level-type requests from on-chip peripherals, plus one non-maskable input, into a vector handed to the core. Each internal request can get through only when its own enable bit is set and the global mask bit is clear. The lowest-numbered eligible source wins. The non-maskable input is taken on its rising edge and outranks every internal source. When a request is accepted, the block raises a one-cycle accept strobe, presents a 5-bit vector code, and pulses a mask-set output so the core can raise its global mask. It accepts nothing further until the core reports that the vector fetch has finished.

The block never clears a peripheral flag. A source that software has not cleared is therefore taken again after the acknowledge. A request is sampled in one cycle and checked again in the next. If software withdraws it in between (by clearing its flag or its enable), the block falls back to the best request still present. If no request is present, it issues the reset vector.

The block also drives a wake output for the power controller. In sleep mode, any eligible internal request or a new non-maskable edge raises wake. In software-standby mode, only one designated input-strobe source can raise wake.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset, accept_o, mask_set_o and wake_o are 0 and vector_o is 0.
- R2: An internal source i is eligible only when req_i[i]=1, en_i[i]=1 and mask_i=0. A source that is not eligible is never accepted.
- R3: Among eligible sources, the lowest index wins. Source i is issued with vector code i+2. A pending non-maskable edge outranks all internal sources.
- R4: A request present at clock edge E0, in the idle state, produces accept_o=1 for exactly one cycle after edge E0+1. vector_o holds its value until the next acceptance.
- R5: mask_set_o pulses together with accept_o for every internal vector and for the reset vector. It stays 0 for the non-maskable vector.
- R6: After an acceptance, no new acceptance occurs until ack_i is sampled high. A flag still set after the acknowledge is accepted again.
- R7: A rising edge on nmi_i is accepted with vector code 1, even when mask_i=1.
- R8: If the captured internal request no longer has req_i and en_i both high at the re-check edge, the lowest-indexed source that does is issued instead.
- R9: If the captured request is withdrawn and no source has req_i and en_i both high, vector code 0 (reset) is issued.
- R10: With sleep_i=1 and standby_i=0, wake_o is 1 one cycle after any eligible internal request or nmi_i rising edge. It is 0 when nothing is eligible.
- R11: With standby_i=1, wake_o follows only the eligibility of source STROBE_IDX (default 16), one cycle later. Every other source is ignored for wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 17 | Peripheral request flag levels |
| en_i | input | 17 | Per-source enable bits |
| mask_i | input | 1 | Global interrupt mask bit |
| nmi_i | input | 1 | Non-maskable request, taken on its rising edge |
| sleep_i | input | 1 | CPU is in sleep mode |
| standby_i | input | 1 | CPU is in software-standby mode |
| ack_i | input | 1 | CPU has completed the vector fetch |
| accept_o | output | 1 | One-cycle acceptance strobe |
| vector_o | output | 5 | Vector code: 0 reset, 1 non-maskable, i+2 for source i |
| mask_set_o | output | 1 | Pulse telling the CPU to set its global mask |
| wake_o | output | 1 | Wake request to the power controller |

## Verification
The bench withdraws a captured request between the sampling edge and the re-check edge. In one case another source is still pending and in the other case none is. A design that skipped the re-check would vector to a source nobody is requesting, and one lacking the fallback would issue nothing or a stale code instead of the next source or the reset code. The bench holds flags set across the acknowledge, which exposes a design that accepts again before ack_i arrives or one that never accepts the uncleared flag again. It also raises the non-maskable edge together with an internal request and while masked, which catches a design that lets the mask block it or lets an internal source win. Standby-mode wake is checked with a non-designated source that is eligible, which catches a design that wakes on any source.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_WAIT    = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 17,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    // lowest index has the highest priority
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_wake_gen.sv
module irq_wake_gen #(
    parameter int N          = 17,
    parameter int STROBE_IDX = 16
) (
    input  logic [N-1:0] elig_i,
    input  logic         nmi_new_i,
    input  logic         sleep_i,
    input  logic         standby_i,
    output logic         wake_d_o
);

    always_comb begin
        if (standby_i) begin
            wake_d_o = elig_i[STROBE_IDX];
        end else if (sleep_i) begin
            wake_d_o = (|elig_i) | nmi_new_i;
        end else begin
            wake_d_o = 1'b0;
        end
    end

endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl #(
    parameter int NUM_SRC    = 17,
    parameter int VEC_W      = 5,
    parameter int VEC_BASE   = 2,
    parameter int RESET_CODE = 0,
    parameter int NMI_CODE   = 1,
    parameter int STROBE_IDX = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               mask_i,
    input  logic               nmi_i,
    input  logic               sleep_i,
    input  logic               standby_i,
    input  logic               ack_i,
    output logic               accept_o,
    output logic [VEC_W-1:0]   vector_o,
    output logic               mask_set_o,
    output logic               wake_o
);
    import irq_wake_pkg::*;

    localparam int IW = $clog2(NUM_SRC);

    typedef struct packed {
        ctl_state_e       state;
        logic             cap_nmi;
        logic [IW-1:0]    cap_idx;
        logic             nmi_prev;
        logic             nmi_pend;
        logic             accept;
        logic             mask_set;
        logic [VEC_W-1:0] vector;
        logic             wake;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic [NUM_SRC-1:0] elig, live;
    logic               elig_found, live_found;
    logic [IW-1:0]      elig_idx, live_idx;
    logic               nmi_rise, nmi_now, wake_d;

    assign elig     = req_i & en_i & {NUM_SRC{~mask_i}};
    assign live     = req_i & en_i;
    assign nmi_rise = nmi_i & ~cur_q.nmi_prev;
    assign nmi_now  = cur_q.nmi_pend | nmi_rise;

    irq_prio_enc #(.N(NUM_SRC), .IW(IW)) u_enc_detect (
        .vec_i   (elig),
        .found_o (elig_found),
        .idx_o   (elig_idx)
    );

    irq_prio_enc #(.N(NUM_SRC), .IW(IW)) u_enc_resolve (
        .vec_i   (live),
        .found_o (live_found),
        .idx_o   (live_idx)
    );

    irq_wake_gen #(.N(NUM_SRC), .STROBE_IDX(STROBE_IDX)) u_wake (
        .elig_i    (elig),
        .nmi_new_i (nmi_rise),
        .sleep_i   (sleep_i),
        .standby_i (standby_i),
        .wake_d_o  (wake_d)
    );

    function automatic logic [VEC_W-1:0] src_code(input logic [IW-1:0] idx);
        return VEC_W'(idx) + VEC_W'(VEC_BASE);
    endfunction

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.accept   = 1'b0;
        nxt_d.mask_set = 1'b0;
        nxt_d.nmi_prev = nmi_i;
        nxt_d.nmi_pend = nmi_now;
        nxt_d.wake     = wake_d;
        case (cur_q.state)
            ST_IDLE: begin
                if (nmi_now) begin
                    nxt_d.cap_nmi = 1'b1;
                    nxt_d.state   = ST_RESOLVE;
                end else if (elig_found) begin
                    nxt_d.cap_nmi = 1'b0;
                    nxt_d.cap_idx = elig_idx;
                    nxt_d.state   = ST_RESOLVE;
                end
            end
            ST_RESOLVE: begin
                nxt_d.state  = ST_WAIT;
                nxt_d.accept = 1'b1;
                if (cur_q.cap_nmi) begin
                    nxt_d.vector   = VEC_W'(NMI_CODE);
                    nxt_d.nmi_pend = nmi_rise;
                end else begin
                    nxt_d.mask_set = 1'b1;
                    if (live[cur_q.cap_idx]) begin
                        nxt_d.vector = src_code(cur_q.cap_idx);
                    end else if (live_found) begin
                        nxt_d.vector = src_code(live_idx);
                    end else begin
                        nxt_d.vector = VEC_W'(RESET_CODE);
                    end
                end
            end
            ST_WAIT: begin
                if (ack_i) nxt_d.state = ST_IDLE;
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, cap_nmi: 1'b0, cap_idx: '0,
                       nmi_prev: 1'b0, nmi_pend: 1'b0, accept: 1'b0,
                       mask_set: 1'b0, vector: '0, wake: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign accept_o   = cur_q.accept;
    assign vector_o   = cur_q.vector;
    assign mask_set_o = cur_q.mask_set;
    assign wake_o     = cur_q.wake;

    p_accept_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !accept_o)
        else $error("accept strobe longer than one cycle");

    p_mask_set_paired_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set_o |-> accept_o)
        else $error("mask_set without accept");

    p_nmi_no_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && vector_o == VEC_W'(NMI_CODE)) |-> !mask_set_o)
        else $error("mask_set on non-maskable vector");

    p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_WAIT && !ack_i) |=> !accept_o)
        else $error("acceptance before acknowledge");

    p_vector_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (vector_o <= VEC_W'(NUM_SRC + VEC_BASE - 1)))
        else $error("vector code out of range");

    p_vector_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_o && !$rose(accept_o)) |=> (accept_o || $stable(vector_o)))
        else $error("vector changed without acceptance");

    p_standby_strobe_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_i && !(req_i[STROBE_IDX] && en_i[STROBE_IDX] && !mask_i)) |=> !wake_o)
        else $error("standby wake from a non-strobe source");

endmodule

// File: tb/irq_wake_ctrl_tb.sv
module irq_wake_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N = 17;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] en_i = '0;
    logic         mask_i = 1'b0;
    logic         nmi_i = 1'b0;
    logic         sleep_i = 1'b0;
    logic         standby_i = 1'b0;
    logic         ack_i = 1'b0;
    logic         accept_o;
    logic [4:0]   vector_o;
    logic         mask_set_o;
    logic         wake_o;

    int n_cmp = 0;
    int n_bad = 0;
    int acc_cnt = 0;
    logic [5:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_wake_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .en_i(en_i),
        .mask_i(mask_i), .nmi_i(nmi_i), .sleep_i(sleep_i),
        .standby_i(standby_i), .ack_i(ack_i), .accept_o(accept_o),
        .vector_o(vector_o), .mask_set_o(mask_set_o), .wake_o(wake_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // driver side: queue an expected {mask_set, vector}
    task automatic expect_acc(input int vec, input bit ms);
        exp_q.push_back({ms, 5'(vec)});
    endtask

    // monitor: every accept pops one expected item
    always @(negedge clk) begin
        if (rst_n && accept_o) begin
            acc_cnt++;
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2/R6: unexpected accept vector %0d expected none", vector_o);
            end else begin
                logic [5:0] e;
                e = exp_q.pop_front();
                if ({mask_set_o, vector_o} != e) begin
                    n_bad++;
                    $display("FAIL R3/R5/R8/R9: actual ms=%0d vec=%0d expected ms=%0d vec=%0d",
                             mask_set_o, vector_o, e[5], e[4:0]);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack;
        ack_i = 1'b1;
        cyc(1);
        ack_i = 1'b0;
    endtask

    task automatic wait_acc(input int target, input string tag);
        int t = 0;
        while (acc_cnt < target && t < 10) begin
            cyc(1);
            t++;
        end
        chk(tag, acc_cnt, target);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cyc(2);
        // R1 reset state
        chk("R1 accept", accept_o, 0);
        chk("R1 mask_set", mask_set_o, 0);
        chk("R1 wake", wake_o, 0);
        chk("R1 vector", vector_o, 0);
        rst_n = 1'b1;
        cyc(2);

        // R2 masked and disabled sources are not accepted
        mask_i = 1'b1; req_i[2] = 1'b1; en_i[2] = 1'b1;
        cyc(5);
        chk("R2 masked", acc_cnt, 0);
        mask_i = 1'b0; en_i[2] = 1'b0;
        cyc(5);
        chk("R2 disabled", acc_cnt, 0);
        req_i = '0; en_i = '1;

        // R3/R4 priority and latency: sources 5 and 9, lower wins
        req_i[5] = 1'b1; req_i[9] = 1'b1;
        expect_acc(7, 1);
        cyc(1);
        chk("R4 not yet", accept_o, 0);
        cyc(1);
        chk("R4 accept", accept_o, 1);
        chk("R3 vector", vector_o, 7);
        cyc(1);
        chk("R4 one cycle", accept_o, 0);
        chk("R4 vector held", vector_o, 7);
        // R6 flags still set: nothing before ack
        cyc(4);
        chk("R6 hold", acc_cnt, 1);
        req_i[5] = 1'b0;
        expect_acc(11, 1);
        do_ack;
        wait_acc(2, "R6 reaccept");
        req_i = '0;
        do_ack;
        cyc(2);

        // R7 non-maskable edge while masked
        mask_i = 1'b1; req_i[0] = 1'b1;
        expect_acc(1, 0);
        nmi_i = 1'b1;
        cyc(1);
        nmi_i = 1'b0;
        wait_acc(3, "R7 masked nmi");
        do_ack;
        cyc(3);
        chk("R7 no internal", acc_cnt, 3);
        // R3 nmi outranks source 0 when unmasked
        mask_i = 1'b0;
        expect_acc(1, 0);
        expect_acc(2, 1);
        nmi_i = 1'b1;
        cyc(1);
        nmi_i = 1'b0;
        wait_acc(4, "R3 nmi first");
        do_ack;
        wait_acc(5, "R3 source0 after");
        req_i = '0;
        do_ack;
        cyc(2);

        // R8 withdrawal falls back to next pending
        req_i[3] = 1'b1; req_i[5] = 1'b1;
        expect_acc(7, 1);
        cyc(1);
        req_i[3] = 1'b0;
        wait_acc(6, "R8 fallback");
        req_i = '0;
        do_ack;
        cyc(2);

        // R9 withdrawal with nothing left gives reset code
        req_i[3] = 1'b1;
        expect_acc(0, 1);
        cyc(1);
        en_i[3] = 1'b0;
        wait_acc(7, "R9 reset code");
        req_i = '0; en_i = '1;
        do_ack;
        cyc(2);

        // R10 sleep wake
        sleep_i = 1'b1; mask_i = 1'b1; req_i[6] = 1'b1;
        cyc(2);
        chk("R10 masked no wake", wake_o, 0);
        mask_i = 1'b0;
        expect_acc(8, 1);
        cyc(1);
        chk("R10 wake", wake_o, 1);
        wait_acc(8, "R10 accept");
        req_i = '0;
        do_ack;
        cyc(1);
        chk("R10 wake drops", wake_o, 0);
        sleep_i = 1'b0;

        // R11 standby: only the strobe source wakes
        standby_i = 1'b1;
        req_i[6] = 1'b1;
        expect_acc(8, 1);
        cyc(1);
        chk("R11 other no wake", wake_o, 0);
        wait_acc(9, "R11 accept other");
        req_i = '0;
        do_ack;
        req_i[16] = 1'b1;
        expect_acc(18, 1);
        cyc(1);
        chk("R11 strobe wake", wake_o, 1);
        wait_acc(10, "R11 accept strobe");
        req_i = '0;
        do_ack;
        standby_i = 1'b0;
        cyc(3);
        chk("R11 wake clear", wake_o, 0);
        chk("R6 queue drained", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule